// File: doc/BRIEF.md
# Serial Link Rate Timing Selector

This block sits beside a high-speed serial transmitter and decides which set of nine lane timing counts the transmitter uses. A 2-bit rate code picks one of three lane rates or a reserved value. For the two faster rates the block holds fixed timing tables. For the slowest rate it always takes its counts from nine software-written registers. At either fast rate, any single parameter can be replaced by its software register when that register's enable bit is set.

The block also reports the lane rate as a multiple of the reference clock. The codes give multiples of 64, 32 and 16. At a 25 MHz reference these are 1600, 800 and 400 Mbps per lane. The net video bandwidth is twice the per-lane figure. New counts are taken only while the transmitter reports that it is idle, so a change never lands in the middle of a packet. The reserved code freezes the outputs and raises a sticky error.

A small state machine tracks the conditions for taking new counts:

- The states are TRACK (idle with a legal code), HOLD (transmitter busy) and RSVD (reserved code selected).
- The named transitions are TRACK->HOLD on busy, HOLD->TRACK on idle, and TRACK/HOLD->RSVD on code 01.
- The state leaves RSVD for TRACK or HOLD once a legal code returns.
- Reset enters HOLD.

Top module: `lrt_sel`

## Requirements
- R1: After reset, `tim_out` is all zero, `rate_mult` is 0 and `rsv_err` is 0.
- R2: With code 00, the transmitter idle and no enable bits set, the next cycle shows the fast table on `tim_out` and `rate_mult` = 64. The fast table is 7, 31, 10, 16, 8, 14, 10, 16, 8.
- R3: With code 10 and the transmitter idle, the next cycle shows the mid table and `rate_mult` = 32. The mid table is 4, 16, 6, 10, 5, 8, 6, 9, 5.
- R4: With code 11 and the transmitter idle, every parameter takes bits 6:0 of its software register, whatever bit 7 holds, and `rate_mult` = 16.
- R5: With code 00 or 10, a parameter whose software register has bit 7 set takes that register's bits 6:0. The other parameters keep their table values.
- R6: Register address k (0..8) holds parameter k, and parameter k drives `tim_out[7k+6:7k]`. The parameter order is clock prepare, clock zero, clock trail, clock post, data prepare, data zero, data trail, data exit, low-power period. Writes to addresses 9..15 change nothing.
- R7: While `tx_idle` is 0, `tim_out` and `rate_mult` hold their values.
- R8: Code 01 leaves `tim_out` and `rate_mult` unchanged. It sets `rsv_err` on the next cycle, and `rsv_err` stays set until reset.
- R9: A register write takes one cycle to become visible, and the output changes one further idle cycle later. Counts are computed from the register contents held before the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Bit 7 enable, bits 6:0 count |
| rate_code | input | 2 | 00 fast, 01 reserved, 10 mid, 11 slow |
| tx_idle | input | 1 | Transmitter between packets |
| tim_out | output | 63 | Nine 7-bit active counts |
| rate_mult | output | 7 | Lane rate over reference clock |
| rsv_err | output | 1 | Sticky reserved-code flag |

## Verification
The directed sequences try each code with every enable bit clear, which checks the two tables apart from each other. The same codes are then tried with selected enable bits set, which shows whether a parameter-wise override leaks onto its neighbours. The slow code is loaded with the recommended slow-rate set (0x83, 0x8D, 0x87, 0x87, 0x83, 0x86, 0x84, 0x86, 0x84), which shows that bit 7 is ignored there. A random phase mixes busy cycles, reserved codes and writes to all sixteen addresses, which separates the hold, freeze and address-decode behaviour from the selection path.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
    localparam int NPARAM = 9;
    localparam int CNT_W  = 7;
    localparam int REG_W  = CNT_W + 1;
    localparam int ADDR_W = 4;
    localparam int MULT_W = 7;

    typedef enum logic [1:0] {
        RC_FAST = 2'b00,
        RC_RSVD = 2'b01,
        RC_MID  = 2'b10,
        RC_SLOW = 2'b11
    } rate_e;

    typedef enum logic [1:0] {
        S_TRACK = 2'b00,
        S_HOLD  = 2'b01,
        S_RSVD  = 2'b10
    } state_e;

    function automatic logic [CNT_W-1:0] builtin_count(input logic fast, input int idx);
        unique case (idx)
            0: return fast ? 7'd7  : 7'd4;
            1: return fast ? 7'd31 : 7'd16;
            2: return fast ? 7'd10 : 7'd6;
            3: return fast ? 7'd16 : 7'd10;
            4: return fast ? 7'd8  : 7'd5;
            5: return fast ? 7'd14 : 7'd8;
            6: return fast ? 7'd10 : 7'd6;
            7: return fast ? 7'd16 : 7'd9;
            8: return fast ? 7'd8  : 7'd5;
            default: return '0;
        endcase
    endfunction

    function automatic logic [MULT_W-1:0] rate_multiple(input rate_e code);
        unique case (code)
            RC_FAST: return 7'd64;
            RC_MID:  return 7'd32;
            RC_SLOW: return 7'd16;
            default: return 7'd0;
        endcase
    endfunction
endpackage

// File: rtl/lrt_regs.sv
module lrt_regs
    import lrt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [REG_W-1:0]        wr_data,
    output logic [NPARAM*REG_W-1:0] regs_flat
);
    for (genvar i = 0; i < NPARAM; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_flat[i*REG_W +: REG_W] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(i)))
                regs_flat[i*REG_W +: REG_W] <= wr_data;
        end
    end
endmodule

// File: rtl/lrt_mux.sv
module lrt_mux
    import lrt_pkg::*;
(
    input  logic [1:0]              rate_code,
    input  logic [NPARAM*REG_W-1:0] regs_flat,
    output logic [NPARAM*CNT_W-1:0] sel_flat,
    output logic [MULT_W-1:0]       sel_mult
);
    rate_e code;
    logic  no_table;
    logic  fast;

    assign code     = rate_e'(rate_code);
    assign no_table = (code == RC_SLOW);
    assign fast     = (code == RC_FAST);
    assign sel_mult = rate_multiple(code);

    for (genvar i = 0; i < NPARAM; i++) begin : g_sel
        logic [REG_W-1:0] r;
        logic             ovr;
        assign r   = regs_flat[i*REG_W +: REG_W];
        assign ovr = r[REG_W-1] || no_table;
        assign sel_flat[i*CNT_W +: CNT_W] = ovr ? r[CNT_W-1:0] : builtin_count(fast, i);
    end
endmodule

// File: rtl/lrt_fsm.sv
module lrt_fsm
    import lrt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_code,
    input  logic       tx_idle,
    output logic       load,
    output logic       rsv_err
);
    state_e state, nxt;
    logic   rsvd;

    assign rsvd = (rate_e'(rate_code) == RC_RSVD);

    always_comb begin
        nxt = state;
        unique case (state)
            S_TRACK: begin
                if (rsvd)          nxt = S_RSVD;
                else if (!tx_idle) nxt = S_HOLD;
            end
            S_HOLD: begin
                if (rsvd)         nxt = S_RSVD;
                else if (tx_idle) nxt = S_TRACK;
            end
            S_RSVD: begin
                if (!rsvd) nxt = tx_idle ? S_TRACK : S_HOLD;
            end
            default: nxt = S_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_HOLD;
        else        state <= nxt;
    end

    assign load = (nxt == S_TRACK);

    always_ff @(posedge clk) begin
        if (!rst_n)               rsv_err <= 1'b0;
        else if (nxt == S_RSVD)   rsv_err <= 1'b1;
    end
endmodule

// File: rtl/lrt_sel.sv
module lrt_sel
    import lrt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [REG_W-1:0]        wr_data,
    input  logic [1:0]              rate_code,
    input  logic                    tx_idle,
    output logic [NPARAM*CNT_W-1:0] tim_out,
    output logic [MULT_W-1:0]       rate_mult,
    output logic                    rsv_err
);
    logic [NPARAM*REG_W-1:0] regs_flat;
    logic [NPARAM*CNT_W-1:0] sel_flat;
    logic [MULT_W-1:0]       sel_mult;
    logic                    load;

    lrt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .regs_flat(regs_flat)
    );

    lrt_mux u_mux (
        .rate_code(rate_code), .regs_flat(regs_flat),
        .sel_flat(sel_flat), .sel_mult(sel_mult)
    );

    lrt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .tx_idle(tx_idle),
        .load(load), .rsv_err(rsv_err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim_out   <= '0;
            rate_mult <= '0;
        end else if (load) begin
            tim_out   <= sel_flat;
            rate_mult <= sel_mult;
        end
    end
endmodule

// File: rtl/lrt_sel_chk.sv
module lrt_sel_chk
    import lrt_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic [1:0]              rate_code,
    input logic                    tx_idle,
    input logic [NPARAM*CNT_W-1:0] tim_out,
    input logic [MULT_W-1:0]       rate_mult,
    input logic                    rsv_err
);
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_idle |=> ($stable(tim_out) && $stable(rate_mult))); // R7
    AST_RSVD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_code == 2'b01) |=> ($stable(tim_out) && $stable(rate_mult))); // R8
    AST_RSVD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_code == 2'b01) |=> rsv_err); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_err |=> rsv_err); // R8
    AST_MULT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_idle && rate_code == 2'b00) |=> (rate_mult == 7'd64)); // R2
    AST_MULT_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_idle && rate_code == 2'b10) |=> (rate_mult == 7'd32)); // R3
    AST_MULT_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_idle && rate_code == 2'b11) |=> (rate_mult == 7'd16)); // R4
    AST_MULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rate_mult)); // R2
endmodule

bind lrt_sel lrt_sel_chk chk_i (
    .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .tx_idle(tx_idle),
    .tim_out(tim_out), .rate_mult(rate_mult), .rsv_err(rsv_err)
);

// File: tb/lrt_sel_tb_top.sv
module lrt_sel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rate_code = 2'b00;
    logic        tx_idle = 1'b0;
    logic [62:0] tim_out;
    logic [6:0]  rate_mult;
    logic        rsv_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  m_sw [9];
    logic [6:0]  m_tim [9];
    logic [6:0]  m_mult;
    logic        m_err;

    always #2 clk = ~clk;

    lrt_sel dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rate_code(rate_code), .tx_idle(tx_idle),
        .tim_out(tim_out), .rate_mult(rate_mult), .rsv_err(rsv_err)
    );

    function automatic logic [6:0] tbl(input logic fast, input int k);
        logic [6:0] f [9] = '{7'd7, 7'd31, 7'd10, 7'd16, 7'd8, 7'd14, 7'd10, 7'd16, 7'd8};
        logic [6:0] m [9] = '{7'd4, 7'd16, 7'd6, 7'd10, 7'd5, 7'd8, 7'd6, 7'd9, 7'd5};
        return fast ? f[k] : m[k];
    endfunction

    function automatic logic [6:0] mult_of(input logic [1:0] c);
        return (c == 2'b00) ? 7'd64 : (c == 2'b10) ? 7'd32 : (c == 2'b11) ? 7'd16 : 7'd0;
    endfunction

    function automatic logic [62:0] pack_tim();
        logic [62:0] v;
        for (int k = 0; k < 9; k++) v[k*7 +: 7] = m_tim[k];
        return v;
    endfunction

    task automatic chk(input string tag, input logic [62:0] act, input logic [62:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycle(input string tag, input logic [1:0] c, input logic idle,
                         input logic we, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        rate_code = c; tx_idle = idle; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        if (c != 2'b01 && idle) begin
            for (int k = 0; k < 9; k++)
                m_tim[k] = (m_sw[k][7] || c == 2'b11) ? m_sw[k][6:0] : tbl(c == 2'b00, k);
            m_mult = mult_of(c);
        end
        if (c == 2'b01) m_err = 1'b1;
        if (we && a < 4'd9) m_sw[a] = d;
        #1;
        chk(tag, tim_out, pack_tim());
        chk(tag, 63'(rate_mult), 63'(m_mult));
        chk("R8", 63'(rsv_err), 63'(m_err));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rec [9] = '{8'h83, 8'h8D, 8'h87, 8'h87, 8'h83, 8'h86, 8'h84, 8'h86, 8'h84};
        void'($urandom(32'd4711));
        for (int k = 0; k < 9; k++) begin m_sw[k] = '0; m_tim[k] = '0; end
        m_mult = '0; m_err = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", tim_out, '0);
        chk("R1", 63'(rate_mult), '0);
        chk("R1", 63'(rsv_err), '0);
        @(negedge clk); rst_n = 1'b1;

        cycle("R2", 2'b00, 1'b1, 1'b0, 4'd0, 8'h00);
        chk("R2", tim_out, {7'd8, 7'd16, 7'd10, 7'd14, 7'd8, 7'd16, 7'd10, 7'd31, 7'd7});
        cycle("R3", 2'b10, 1'b1, 1'b0, 4'd0, 8'h00);
        chk("R3", tim_out, {7'd5, 7'd9, 7'd6, 7'd8, 7'd5, 7'd10, 7'd6, 7'd16, 7'd4});

        for (int k = 0; k < 9; k++) cycle("R6", 2'b10, 1'b1, 1'b1, 4'(k), rec[k]);
        cycle("R4", 2'b11, 1'b1, 1'b0, 4'd0, 8'h00);
        chk("R4", tim_out, {7'h04, 7'h06, 7'h04, 7'h06, 7'h03, 7'h07, 7'h07, 7'h0D, 7'h03});
        chk("R4", 63'(rate_mult), 63'(7'd16));

        cycle("R5", 2'b00, 1'b1, 1'b0, 4'd0, 8'h00);
        cycle("R5", 2'b00, 1'b1, 1'b1, 4'd2, 8'h05);
        cycle("R9", 2'b00, 1'b1, 1'b0, 4'd0, 8'h00);
        chk("R9", 63'(tim_out[20:14]), 63'(7'd10));

        for (int a = 9; a < 16; a++) cycle("R6", 2'b11, 1'b1, 1'b1, 4'(a), 8'hFF);

        cycle("R7", 2'b10, 1'b0, 1'b1, 4'd0, 8'h11);
        cycle("R7", 2'b00, 1'b0, 1'b0, 4'd0, 8'h00);
        cycle("R7", 2'b00, 1'b1, 1'b0, 4'd0, 8'h00);

        cycle("R8", 2'b01, 1'b1, 1'b0, 4'd0, 8'h00);
        chk("R8", 63'(rsv_err), 63'(1'b1));
        cycle("R8", 2'b10, 1'b1, 1'b0, 4'd0, 8'h00);
        chk("R8", 63'(rsv_err), 63'(1'b1));

        for (int n = 0; n < 400; n++) begin
            int r = $urandom % 8;
            logic [1:0] c = (r < 3) ? 2'b00 : (r < 5) ? 2'b10 : (r < 7) ? 2'b11 : 2'b01;
            logic idle = ($urandom % 4) != 0;
            string tag = (c == 2'b01) ? "R8" : !idle ? "R7" : (c == 2'b11) ? "R4" : "R5";
            cycle(tag, c, idle, 1'($urandom % 2), 4'($urandom % 16), 8'($urandom % 256));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule